// File: doc/BRIEF.md
# Crypto Engine Register and Interrupt Unit

This block is the 32-bit register window of a crypto engine. Software reads a fixed status word, a queue-status word, a watermark word and the last flag value posted by the command decoder. It also reads and writes an interrupt-enable mask and an interrupt-cause register. Writes to the queue port are passed straight to the command decoder as a one-cycle push.

The decoder reports two events to the block: an invalid command and a flag command. Each event latches a cause bit. Software clears a cause bit by writing a 1 to it. A single level interrupt is high while any latched cause is also enabled.

Reads are combinational on the byte address. All accesses are 4-byte accesses.

Top module: `crypto_regs`

## Requirements
- R1: After reset, the block reads back as follows: status (0x0C) = 0x00003F80, queue status (0x24) = 0x00000002, interrupt causes (0x18) = 0, interrupt enable (0x1C) = 0, watermark (0x20) = 0, flag info (0x30) = 0.
- R2: Reads use the map in R1. The status, queue-status and watermark words never change.
- R3: Writing offset 0x18 clears every cause bit written as 1 and leaves the bits written as 0 unchanged.
- R4: `irq` is high exactly when (causes AND enable) is non-zero. It follows each write or event on the next clock edge.
- R5: A pulse on `ev_invalid_cmd` sets cause bit 2, and a pulse on `ev_flag` sets cause bit 5. No other cause bit can ever be set.
- R6: An event that arrives in the same cycle as a write-one-to-clear of its own bit leaves the bit set.
- R7: Offset 0x1C is a full 32-bit read/write enable mask.
- R8: A write to offset 0x200 raises `q_push` in that same cycle, with `q_data` equal to the written word. No other offset raises `q_push`.
- R9: Reads of undefined offsets return 0. Writes to undefined offsets, or to the read-only words, change no readable state.
- R10: Offset 0x30 holds the last 8-bit value presented with `flag_wr`, with bits 31:8 reading 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one word per cycle |
| bus_addr | input | 14 | Byte address within the window |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr (combinational) |
| q_push | output | 1 | Queue word push to the decoder |
| q_data | output | 32 | Queue word |
| ev_invalid_cmd | input | 1 | Decoder event: invalid command |
| ev_flag | input | 1 | Decoder event: flag with interrupt |
| flag_wr | input | 1 | Decoder updates the flag value |
| flag_val | input | 8 | New flag value |
| irq | output | 1 | Level interrupt |

## Verification
Each event is raised on its own, then both together, so that a swapped or shared bit position shows up in the cause readback. Clears are written one bit at a time, with all ones, and in the same cycle as a matching event, which separates a plain overwrite, a clear of the wrong bits and a lost event. The enable mask is set to all ones, then to each single cause, then to zero, to show that the interrupt depends on both registers and not on the causes alone. Writes to read-only, undefined and near-miss addresses, including the word beside the queue port, show that only the decoded offsets respond.

// File: rtl/crypto_regs.sv
module crypto_regs #(
  parameter int AW = 14,
  parameter int DW = 32,
  parameter int FW = 8,
  parameter logic [31:0] STATUS_VAL = 32'h0000_3F80,
  parameter logic [31:0] QSTAT_VAL  = 32'h0000_0002,
  parameter logic [31:0] WMARK_VAL  = 32'h0000_0000
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [DW-1:0] bus_wdata,
  output logic [DW-1:0] bus_rdata,
  output logic          q_push,
  output logic [DW-1:0] q_data,
  input  logic          ev_invalid_cmd,
  input  logic          ev_flag,
  input  logic          flag_wr,
  input  logic [FW-1:0] flag_val,
  output logic          irq
);
  localparam logic [AW-1:0] OFF_STAT  = AW'('h00C);
  localparam logic [AW-1:0] OFF_CAUSE = AW'('h018);
  localparam logic [AW-1:0] OFF_EN    = AW'('h01C);
  localparam logic [AW-1:0] OFF_WMARK = AW'('h020);
  localparam logic [AW-1:0] OFF_QSTAT = AW'('h024);
  localparam logic [AW-1:0] OFF_FLAG  = AW'('h030);
  localparam logic [AW-1:0] OFF_QUEUE = AW'('h200);
  localparam int INV_BIT  = 2;
  localparam int FLAG_BIT = 5;

  logic [DW-1:0] cause, cause_en, clr_mask, ev_vec;
  logic [FW-1:0] flag_info;

  assign clr_mask = (bus_wr && bus_addr == OFF_CAUSE) ? bus_wdata : '0;

  always_comb begin
    ev_vec = '0;
    ev_vec[INV_BIT]  = ev_invalid_cmd;
    ev_vec[FLAG_BIT] = ev_flag;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cause     <= '0;
      cause_en  <= '0;
      flag_info <= '0;
    end else begin
      cause <= (cause & ~clr_mask) | ev_vec;
      if (bus_wr && bus_addr == OFF_EN) cause_en <= bus_wdata;
      if (flag_wr) flag_info <= flag_val;
    end
  end

  assign irq    = |(cause & cause_en);
  assign q_push = bus_wr && (bus_addr == OFF_QUEUE);
  assign q_data = bus_wdata;

  always_comb begin
    case (bus_addr)
      OFF_STAT:  bus_rdata = STATUS_VAL;
      OFF_CAUSE: bus_rdata = cause;
      OFF_EN:    bus_rdata = cause_en;
      OFF_WMARK: bus_rdata = WMARK_VAL;
      OFF_QSTAT: bus_rdata = QSTAT_VAL;
      OFF_FLAG:  bus_rdata = {{(DW-FW){1'b0}}, flag_info};
      default:   bus_rdata = '0;
    endcase
  end

  p_w1c_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_CAUSE && bus_wdata[INV_BIT] && !ev_invalid_cmd)
      |=> !cause[INV_BIT]);

  p_irq_off_when_masked_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EN && bus_wdata == '0) |=> !irq);

  p_cause_needs_event_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cause[INV_BIT]) |-> $past(ev_invalid_cmd));

  p_event_beats_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    ev_flag |=> cause[FLAG_BIT]);

  p_enable_written_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == OFF_EN) |=> (cause_en == $past(bus_wdata)));
endmodule

// File: tb/crypto_regs_tb.sv
module crypto_regs_tb_top;
  logic clk = 1'b0, rst_n = 1'b0;
  logic bus_wr = 1'b0;
  logic [13:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata, q_data;
  logic q_push, irq;
  logic ev_inv = 1'b0, ev_flg = 1'b0, fwr = 1'b0;
  logic [7:0] fval = '0;
  int checks = 0, fails = 0, cycles = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  crypto_regs dut_i (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .q_push(q_push),
    .q_data(q_data), .ev_invalid_cmd(ev_inv), .ev_flag(ev_flg),
    .flag_wr(fwr), .flag_val(fval), .irq(irq));

  // reference model
  logic [31:0] m_cause, m_en;
  logic [7:0]  m_flag;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_cause <= 0; m_en <= 0; m_flag <= 0;
    end else begin : upd
      logic [31:0] nxt;
      nxt = m_cause;
      if (bus_wr && bus_addr == 14'h018) nxt = nxt & ~bus_wdata;
      if (ev_inv) nxt = nxt | 32'h4;
      if (ev_flg) nxt = nxt | 32'h20;
      m_cause <= nxt;
      if (bus_wr && bus_addr == 14'h01C) m_en <= bus_wdata;
      if (fwr) m_flag <= fval;
    end
  end

  function automatic logic [31:0] m_read(logic [13:0] a);
    case (a)
      14'h00C: return 32'h3F80;
      14'h018: return m_cause;
      14'h01C: return m_en;
      14'h020: return 32'h0;
      14'h024: return 32'h2;
      14'h030: return {24'h0, m_flag};
      default: return 32'h0;
    endcase
  endfunction

  task automatic chk(logic [31:0] act, logic [31:0] exp, string tag);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model, half a period after the edge
  always begin
    @(negedge clk); #2;
    if (rst_n && !done) begin
      chk(bus_rdata, m_read(bus_addr), "R2 model readback");
      chk({31'h0, irq}, {31'h0, (m_cause & m_en) != 0}, "R4 model irq");
      chk({31'h0, q_push}, {31'h0, bus_wr && bus_addr == 14'h200}, "R8 model push");
      if (q_push) chk(q_data, bus_wdata, "R8 model data");
    end
  end

  task automatic cyc(logic w, logic [13:0] a, logic [31:0] d,
                     logic ei, logic ef, logic fw, logic [7:0] fv);
    @(posedge clk); #2;
    bus_wr = w; bus_addr = a; bus_wdata = d;
    ev_inv = ei; ev_flg = ef; fwr = fw; fval = fv;
  endtask

  task automatic idle(logic [13:0] a);
    cyc(0, a, 0, 0, 0, 0, 0);
  endtask

  task automatic rd(logic [13:0] a, logic [31:0] exp, string tag);
    idle(a); #10;
    chk(bus_rdata, exp, tag);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    rd(14'h00C, 32'h3F80, "R1 status");
    rd(14'h024, 32'h2, "R1 qstatus");
    rd(14'h018, 32'h0, "R1 causes");
    rd(14'h01C, 32'h0, "R1 enable");
    rd(14'h020, 32'h0, "R1 watermark");
    rd(14'h030, 32'h0, "R1 flag");
    chk({31'h0, irq}, 32'h0, "R1 irq");
    cyc(1, 14'h01C, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(14'h01C, 32'hFFFF_FFFF, "R7 enable all ones");
    chk({31'h0, irq}, 32'h0, "R4 no cause no irq");
    cyc(0, 14'h018, 0, 1, 0, 0, 0);
    rd(14'h018, 32'h4, "R5 invalid bit2");
    chk({31'h0, irq}, 32'h1, "R4 irq raised");
    cyc(0, 14'h030, 0, 0, 1, 1, 8'hA5);
    rd(14'h018, 32'h24, "R5 flag bit5");
    rd(14'h030, 32'hA5, "R10 flag value");
    cyc(1, 14'h018, 32'h4, 0, 0, 0, 0);
    rd(14'h018, 32'h20, "R3 clear bit2 only");
    chk({31'h0, irq}, 32'h1, "R4 irq held by bit5");
    cyc(1, 14'h018, 32'h20, 0, 0, 0, 0);
    rd(14'h018, 32'h0, "R3 clear bit5");
    chk({31'h0, irq}, 32'h0, "R4 irq drops");
    cyc(1, 14'h018, 32'h20, 0, 1, 0, 0);
    rd(14'h018, 32'h20, "R6 event beats clear");
    cyc(1, 14'h018, 32'h4, 1, 0, 0, 0);
    rd(14'h018, 32'h24, "R6 invalid beats clear");
    cyc(1, 14'h01C, 32'h4, 0, 0, 0, 0);
    cyc(1, 14'h018, 32'h4, 0, 0, 0, 0);
    rd(14'h018, 32'h20, "R3 partial clear");
    chk({31'h0, irq}, 32'h0, "R4 bit5 masked");
    cyc(0, 14'h018, 0, 1, 0, 0, 0);
    idle(14'h018); #10;
    chk({31'h0, irq}, 32'h1, "R4 bit2 enabled");
    cyc(1, 14'h01C, 32'h0, 0, 0, 0, 0);
    idle(14'h018); #10;
    chk({31'h0, irq}, 32'h0, "R4 enable zero");
    cyc(1, 14'h018, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(14'h018, 32'h0, "R3 clear all");
    cyc(1, 14'h200, 32'h5000_0000, 0, 0, 0, 0); #10;
    chk({31'h0, q_push}, 32'h1, "R8 push");
    chk(q_data, 32'h5000_0000, "R8 data");
    cyc(1, 14'h204, 32'h1, 0, 0, 0, 0); #10;
    chk({31'h0, q_push}, 32'h0, "R8 neighbour no push");
    cyc(1, 14'h00C, 32'h0, 0, 0, 0, 0);
    cyc(1, 14'h020, 32'h77, 0, 0, 0, 0);
    cyc(1, 14'h024, 32'h0, 0, 0, 0, 0);
    cyc(1, 14'h100, 32'hFFFF_FFFF, 0, 0, 0, 0);
    rd(14'h00C, 32'h3F80, "R9 status read-only");
    rd(14'h020, 32'h0, "R9 watermark read-only");
    rd(14'h024, 32'h2, "R9 qstatus read-only");
    rd(14'h100, 32'h0, "R9 undefined read");
    rd(14'h01C, 32'h0, "R9 enable untouched");
    rd(14'h018, 32'h0, "R9 causes untouched");
    rd(14'h01D, 32'h0, "R9 unaligned read");
    cyc(0, 14'h030, 0, 0, 0, 1, 8'h3C);
    rd(14'h030, 32'h3C, "R10 flag update");
    cyc(0, 14'h030, 0, 0, 0, 0, 8'hFF);
    rd(14'h030, 32'h3C, "R10 flag held");
    repeat (2) idle(14'h0);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 5000 && !done) begin
      done = 1'b1;
      checks++; fails++;
      $display("FAIL watchdog actual=%0d expected<5000", cycles);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule